// File: doc/BRIEF.md
# Coarse Carrier Frequency Compensator

This streaming block removes a residual carrier frequency offset from complex fixed-point baseband samples. It accepts one I/Q pair on each cycle that `in_valid` is high. For each sample it forms the product of the sample with the conjugate of the previous sample, which is a cheap per-sample phase-step metric. A first-order recursive smoother averages that metric, taking the place of a long correlation. A pipelined shift-add CORDIC in vectoring mode turns the smoothed vector into an angle. That angle is the estimated phase advance per sample.

The estimate is subtracted into a phase accumulator on every sample. The top bits of the accumulator address a quarter-wave sine table, which yields a unit complex exponential. The input sample is held in a delay line that matches the estimator pipeline exactly. It is then multiplied by that exponential, rounded and saturated back to the input width, and presented with `out_valid`. Cycles without `in_valid` leave every piece of state untouched, so the input stream may carry gaps.

Top module: `ccfc_top`

## Requirements
- R1: `out_valid` rises exactly 22 cycles after each accepted input sample and at no other time; while `rst_n` is low, `out_valid`, `out_re` and `out_im` are 0.
- R2: For accepted sample n, the metric is p = x[n]·conj(x[n-1]), computed as re = xr·pr + xi·pi and im = xi·pr − xr·pi at full precision. x[-1] is taken as 0 after reset.
- R3: The smoother holds a 25-bit state per component, starting at 0, and on each accepted sample updates s ← s + ((p − s) >>> 4) using an arithmetic shift.
- R4: The angle comes from 16 CORDIC vectoring iterations on (s_re, s_im). When s_re < 0, the vector is first negated and the angle starts at 32768. Iteration i adds round(atan(2^-i)/π·32768) when y ≥ 0 and subtracts it otherwise. The result is taken modulo 2^16 as a signed angle in which 32768 corresponds to π.
- R5: A 24-bit phase accumulator starts at 0. On each accepted sample it first decreases by angle·256 (mod 2^24), and that new value then rotates the same sample.
- R6: Sine and cosine use the accumulator's top 10 bits a. Table value(a) = round(32767·sin((a+0.5)·π/512)), stored as one quarter wave of 256 entries. Sine reads a and cosine reads (a+256) mod 1024.
- R7: The output is (xr·c − xi·s, xr·s + xi·c). Each part is rounded by adding 2^14 and then arithmetically shifting right by 15, and saturated to the signed 12-bit range [−2048, 2047].
- R8: Cycles with `in_valid` low change no state. The outputs of later samples equal those of the same samples sent without gaps.
- R9: Asserting `rst_n` in the middle of a stream discards samples in flight and returns the previous sample, the smoother and the phase to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_re | input | 12 | Input in-phase part, signed |
| in_im | input | 12 | Input quadrature part, signed |
| out_valid | output | 1 | Corrected sample strobe |
| out_re | output | 12 | Corrected in-phase part, signed |
| out_im | output | 12 | Corrected quadrature part, signed |

## Verification
Some properties are checked on every cycle. The sample delay line and the oscillator stay aligned. The smoother and phase state hold on idle cycles. Each smoother update moves toward the metric without passing it. The CORDIC residue ends inside its magnitude and angle bounds. Every sine/cosine pair lies on the unit circle within rounding. Only the bench scenarios can show that the values are correct bit for bit. These scenarios cover a DC input, an amplitude step, slow and fast tones (including one whose metric falls in the left half-plane), gapped streams, saturating full-scale corners and a reset in mid-stream. Each is compared against a behavioural model of the requirements.

// File: rtl/ccfc_pkg.sv
package ccfc_pkg;

    localparam real PI_R = 3.14159265358979323846;

    // arctangent of 2^-i as a signed fraction of pi at aw bits
    function automatic int atan_code(int i, int aw);
        return int'($floor($atan(2.0 ** (-i)) / PI_R * (2.0 ** (aw - 1)) + 0.5));
    endfunction

    // one entry of a sine table sampled at half-step offsets on a 2^abits circle
    function automatic int qsin_code(int k, int abits, int tw);
        real th;
        th = (real'(k) + 0.5) * 2.0 * PI_R / (2.0 ** abits);
        return int'($floor($sin(th) * (2.0 ** (tw - 1) - 1.0) + 0.5));
    endfunction

endpackage

// File: rtl/ccfc_smoother.sv
module ccfc_smoother #(
    parameter int DW = 12,
    parameter int K  = 4,
    localparam int PW = 2 * DW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    output logic signed [PW-1:0] out_re,
    output logic signed [PW-1:0] out_im
);

    localparam int DFW = PW + 1;

    typedef struct packed {
        logic signed [DW-1:0] pr;
        logic signed [DW-1:0] pi;
        logic                 pv;
        logic signed [PW-1:0] p_re;
        logic signed [PW-1:0] p_im;
        logic                 sv;
        logic signed [PW-1:0] s_re;
        logic signed [PW-1:0] s_im;
    } sm_t;

    sm_t d, q;
    logic signed [DFW-1:0] dif_re, dif_im;

    always_comb begin
        d      = q;
        d.pv   = in_valid;
        d.sv   = q.pv;
        dif_re = DFW'(q.p_re) - DFW'(q.s_re);
        dif_im = DFW'(q.p_im) - DFW'(q.s_im);
        if (in_valid) begin
            d.pr   = in_re;
            d.pi   = in_im;
            d.p_re = PW'(in_re) * PW'(q.pr) + PW'(in_im) * PW'(q.pi);
            d.p_im = PW'(in_im) * PW'(q.pr) - PW'(in_re) * PW'(q.pi);
        end
        if (q.pv) begin
            d.s_re = q.s_re + PW'(dif_re >>> K);
            d.s_im = q.s_im + PW'(dif_im >>> K);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.sv;
    assign out_re    = q.s_re;
    assign out_im    = q.s_im;

    // R8: smoother state is frozen when no metric arrives
    a_r8_smooth_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !q.pv |=> ($stable(q.s_re) && $stable(q.s_im)));

    // R2: previous-sample store only moves on accepted samples
    a_r2_prev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(q.pr) && $stable(q.pi)));

    // R3: an update moves the state toward the metric without overshoot
    a_r3_toward: assert property (@(posedge clk) disable iff (!rst_n)
        q.pv |=> ((($past(q.p_re) >= $past(q.s_re)) && (q.s_re >= $past(q.s_re)) && (q.s_re <= $past(q.p_re)))
               || (($past(q.p_re) <  $past(q.s_re)) && (q.s_re <= $past(q.s_re)) && (q.s_re >= $past(q.p_re)))));

endmodule

// File: rtl/ccfc_cordic.sv
module ccfc_cordic #(
    parameter int IW  = 25,
    parameter int NIT = 16,
    parameter int AW  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [IW-1:0] in_re,
    input  logic signed [IW-1:0] in_im,
    output logic                 out_valid,
    output logic signed [AW-1:0] out_ang
);

    localparam int CW = IW + 2;
    localparam int ZW = AW + 2;
    localparam logic signed [ZW-1:0] ZPI = ZW'(2 ** (AW - 1));

    typedef struct packed {
        logic                 v;
        logic signed [CW-1:0] x;
        logic signed [CW-1:0] y;
        logic signed [ZW-1:0] z;
    } cs_t;

    cs_t st_d [NIT+1];
    cs_t st_q [NIT+1];
    logic signed [ZW-1:0] atab [NIT];

    for (genvar g = 0; g < NIT; g++) begin : g_atan
        localparam int AV = ccfc_pkg::atan_code(g, AW);
        assign atab[g] = ZW'(AV);
    end

    always_comb begin
        st_d[0].v = in_valid;
        if (in_re < 0) begin
            st_d[0].x = -CW'(in_re);
            st_d[0].y = -CW'(in_im);
            st_d[0].z = ZPI;
        end else begin
            st_d[0].x = CW'(in_re);
            st_d[0].y = CW'(in_im);
            st_d[0].z = '0;
        end
        for (int i = 0; i < NIT; i++) begin
            st_d[i+1].v = st_q[i].v;
            if (st_q[i].y >= 0) begin
                st_d[i+1].x = st_q[i].x + (st_q[i].y >>> i);
                st_d[i+1].y = st_q[i].y - (st_q[i].x >>> i);
                st_d[i+1].z = st_q[i].z + atab[i];
            end else begin
                st_d[i+1].x = st_q[i].x - (st_q[i].y >>> i);
                st_d[i+1].y = st_q[i].y + (st_q[i].x >>> i);
                st_d[i+1].z = st_q[i].z - atab[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= NIT; i++) st_q[i] <= '0;
        end else begin
            for (int i = 0; i <= NIT; i++) st_q[i] <= st_d[i];
        end
    end

    assign out_valid = st_q[NIT].v;
    assign out_ang   = st_q[NIT].z[AW-1:0];

    // R4: the residual vector has converged onto the positive real axis
    a_r4_converged: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[NIT].v |-> (st_q[NIT].x >= 0 && st_q[NIT].y <= st_q[NIT].x && -st_q[NIT].y <= st_q[NIT].x));

    // R4: the unwrapped angle stays within pre-rotation plus the summed arctangents
    a_r4_zrange: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[NIT].v |-> (st_q[NIT].z <= ZW'(3 * 2 ** (AW - 1)) && st_q[NIT].z >= -ZW'(2 ** AW)));

endmodule

// File: rtl/ccfc_nco.sv
module ccfc_nco #(
    parameter int AW    = 16,
    parameter int PHW   = 24,
    parameter int LBITS = 10,
    parameter int TW    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [AW-1:0] in_ang,
    output logic                 out_valid,
    output logic signed [TW-1:0] out_cos,
    output logic signed [TW-1:0] out_sin
);

    localparam int QB = LBITS - 2;
    localparam int QN = 2 ** QB;

    typedef struct packed {
        logic                 pv;
        logic [PHW-1:0]       ph;
        logic                 lv;
        logic signed [TW-1:0] c;
        logic signed [TW-1:0] s;
    } nc_t;

    nc_t d, q;
    logic signed [TW-1:0] rom [QN];
    logic [LBITS-1:0]     a_s, a_c;
    logic [QB-1:0]        i_s, i_c;
    logic signed [TW-1:0] m_s, m_c;

    for (genvar g = 0; g < QN; g++) begin : g_rom
        localparam int QV = ccfc_pkg::qsin_code(g, LBITS, TW);
        assign rom[g] = TW'(QV);
    end

    always_comb begin
        d    = q;
        d.pv = in_valid;
        d.lv = q.pv;
        if (in_valid) d.ph = q.ph - {in_ang, {(PHW - AW){1'b0}}};
        a_s = q.ph[PHW-1 -: LBITS];
        a_c = a_s + LBITS'(QN);
        i_s = a_s[LBITS-2] ? ~a_s[QB-1:0] : a_s[QB-1:0];
        i_c = a_c[LBITS-2] ? ~a_c[QB-1:0] : a_c[QB-1:0];
        m_s = rom[i_s];
        m_c = rom[i_c];
        if (q.pv) begin
            d.s = a_s[LBITS-1] ? -m_s : m_s;
            d.c = a_c[LBITS-1] ? -m_c : m_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.lv;
    assign out_cos   = q.c;
    assign out_sin   = q.s;

    // R5: phase only advances on a delivered angle
    a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(q.ph));

    // R6: every sine/cosine pair lies on the unit circle within table rounding
    a_r6_unit: assert property (@(posedge clk) disable iff (!rst_n)
        q.lv |-> ((longint'(q.c) * longint'(q.c) + longint'(q.s) * longint'(q.s)
                   - longint'(2 ** (TW - 1) - 1) * longint'(2 ** (TW - 1) - 1)) <=  longint'(2 ** TW)
               && (longint'(q.c) * longint'(q.c) + longint'(q.s) * longint'(q.s)
                   - longint'(2 ** (TW - 1) - 1) * longint'(2 ** (TW - 1) - 1)) >= -longint'(2 ** TW)));

endmodule

// File: rtl/ccfc_derot.sv
module ccfc_derot #(
    parameter int DW    = 12,
    parameter int TW    = 16,
    parameter int DEPTH = 21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    input  logic                 cs_valid,
    input  logic signed [TW-1:0] cs_cos,
    input  logic signed [TW-1:0] cs_sin,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);

    localparam int MW = DW + TW + 1;
    localparam logic signed [MW-1:0] HALF = MW'(2 ** (TW - 2));
    localparam logic signed [MW-1:0] MAXV = MW'(2 ** (DW - 1) - 1);
    localparam logic signed [MW-1:0] MINV = -MW'(2 ** (DW - 1));

    typedef struct packed {
        logic                 v;
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } smp_t;

    smp_t dl_d [DEPTH];
    smp_t dl_q [DEPTH];
    smp_t o_d, o_q;
    logic signed [MW-1:0] pr_re, pr_im;

    function automatic logic signed [DW-1:0] rnd_sat(input logic signed [MW-1:0] v);
        logic signed [MW-1:0] r;
        r = (v + HALF) >>> (TW - 1);
        if (r > MAXV)      return DW'(MAXV);
        else if (r < MINV) return DW'(MINV);
        else               return DW'(r);
    endfunction

    always_comb begin
        dl_d[0] = '{v: in_valid, re: in_re, im: in_im};
        for (int i = 1; i < DEPTH; i++) dl_d[i] = dl_q[i-1];
        pr_re = MW'(dl_q[DEPTH-1].re) * MW'(cs_cos) - MW'(dl_q[DEPTH-1].im) * MW'(cs_sin);
        pr_im = MW'(dl_q[DEPTH-1].re) * MW'(cs_sin) + MW'(dl_q[DEPTH-1].im) * MW'(cs_cos);
        o_d   = o_q;
        o_d.v = dl_q[DEPTH-1].v;
        if (dl_q[DEPTH-1].v) begin
            o_d.re = rnd_sat(pr_re);
            o_d.im = rnd_sat(pr_im);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) dl_q[i] <= '0;
            o_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) dl_q[i] <= dl_d[i];
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.v;
    assign out_re    = o_q.re;
    assign out_im    = o_q.im;

    // R1: the delayed sample and its rotation arrive on the same cycle
    a_r1_align: assert property (@(posedge clk) disable iff (!rst_n)
        dl_q[DEPTH-1].v == cs_valid);

endmodule

// File: rtl/ccfc_top.sv
module ccfc_top #(
    parameter int DW    = 12,
    parameter int K     = 4,
    parameter int NIT   = 16,
    parameter int AW    = 16,
    parameter int PHW   = 24,
    parameter int LBITS = 10,
    parameter int TW    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);

    localparam int PW  = 2 * DW + 1;
    // metric + smoother (2), pre-rotation (1), iterations, phase (1), table (1)
    localparam int DLY = NIT + 5;

    logic                 s_v, c_v, n_v;
    logic signed [PW-1:0] s_re, s_im;
    logic signed [AW-1:0] c_ang;
    logic signed [TW-1:0] n_cos, n_sin;

    ccfc_smoother #(.DW(DW), .K(K)) u_smooth (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(s_v), .out_re(s_re), .out_im(s_im)
    );

    ccfc_cordic #(.IW(PW), .NIT(NIT), .AW(AW)) u_cordic (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s_v), .in_re(s_re), .in_im(s_im),
        .out_valid(c_v), .out_ang(c_ang)
    );

    ccfc_nco #(.AW(AW), .PHW(PHW), .LBITS(LBITS), .TW(TW)) u_nco (
        .clk(clk), .rst_n(rst_n),
        .in_valid(c_v), .in_ang(c_ang),
        .out_valid(n_v), .out_cos(n_cos), .out_sin(n_sin)
    );

    ccfc_derot #(.DW(DW), .TW(TW), .DEPTH(DLY)) u_derot (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .cs_valid(n_v), .cs_cos(n_cos), .cs_sin(n_sin),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

endmodule

// File: tb/tb_ccfc_top.sv
module tb_ccfc_top;

    localparam int  DW  = 12;
    localparam int  LAT = 22;
    localparam real PI  = 3.14159265358979323846;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_re = '0;
    logic signed [DW-1:0] in_im = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_re, out_im;

    ccfc_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad   = 0;
    string cur_req = "R2";

    typedef struct { int due; int re; int im; } exp_t;
    exp_t eq[$];

    // behavioural state of the requirements model
    longint m_pr = 0, m_pi = 0, m_sr = 0, m_si = 0;
    longint m_ph = 0;

    task automatic chk(bit ok, string tag, string what, int got, int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp_v);
        end
    endtask

    // R4: vectoring angle, 32768 == pi, wrapped to 16 bits
    function automatic longint model_angle(longint xr, longint xi);
        longint x, y, nx, z;
        x = xr; y = xi; z = 0;
        if (x < 0) begin x = -x; y = -y; z = 32768; end
        for (int i = 0; i < 16; i++) begin
            longint at;
            at = longint'($floor($atan(2.0 ** (-i)) / PI * 32768.0 + 0.5));
            if (y >= 0) begin nx = x + (y >>> i); y = y - (x >>> i); z = z + at; end
            else        begin nx = x - (y >>> i); y = y + (x >>> i); z = z - at; end
            x = nx;
        end
        z = z & 65535;
        if (z >= 32768) z = z - 65536;
        return z;
    endfunction

    // R6: table value on a 1024-point circle
    function automatic longint model_tab(longint a);
        return longint'($floor(32767.0 * $sin((real'(a) + 0.5) * PI / 512.0) + 0.5));
    endfunction

    // R7: round half up by 2^15, clamp to 12 bits
    function automatic int model_rs(longint v);
        longint r;
        r = (v + 16384) >>> 15;
        if (r > 2047) r = 2047;
        if (r < -2048) r = -2048;
        return int'(r);
    endfunction

    task automatic model_step(int xr, int xi, output int yr, output int yi);
        longint pre, pim, ang, a, sn, cs;
        // R2: lag-one conjugate product
        pre = longint'(xr) * m_pr + longint'(xi) * m_pi;
        pim = longint'(xi) * m_pr - longint'(xr) * m_pi;
        m_pr = xr; m_pi = xi;
        // R3: recursive smoothing with shift 4
        m_sr = m_sr + ((pre - m_sr) >>> 4);
        m_si = m_si + ((pim - m_si) >>> 4);
        ang = model_angle(m_sr, m_si);
        // R5: accumulator update, then use
        m_ph = (m_ph - ang * 256) & 64'hFFFFFF;
        a  = m_ph >> 14;
        sn = model_tab(a);
        cs = model_tab((a + 256) & 1023);
        yr = model_rs(longint'(xr) * cs - longint'(xi) * sn);
        yi = model_rs(longint'(xr) * sn + longint'(xi) * cs);
    endtask

    task automatic push(int xr, int xi);
        int yr, yi;
        @(negedge clk);
        in_valid = 1'b1;
        in_re    = DW'(xr);
        in_im    = DW'(xi);
        model_step(xr, xi, yr, yi);
        eq.push_back('{cyc + LAT, yr, yi});
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic tone(real f, real amp, int n, int gap_mod);
        for (int k = 0; k < n; k++) begin
            if (gap_mod > 0 && (k % gap_mod) == gap_mod - 1) idle(1 + (k % 2));
            push(int'($floor(amp * $cos(2.0 * PI * f * k) + 0.5)),
                 int'($floor(amp * $sin(2.0 * PI * f * k) + 0.5)));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        eq.delete();
        m_pr = 0; m_pi = 0; m_sr = 0; m_si = 0; m_ph = 0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
        chk(out_re == 0, "R9", "reset out_re", int'(out_re), 0);
        chk(out_im == 0, "R9", "reset out_im", int'(out_im), 0);
        rst_n = 1'b1;
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit ev;
            exp_t e;
            while (eq.size() > 0 && eq[0].due < cyc) void'(eq.pop_front());
            ev = (eq.size() > 0 && eq[0].due == cyc);
            chk(out_valid == ev, "R1", "out_valid timing", int'(out_valid), int'(ev));
            if (ev) begin
                e = eq.pop_front();
                if (out_valid) begin
                    chk(int'(out_re) == e.re, cur_req, "out_re", int'(out_re), e.re);
                    chk(int'(out_im) == e.im, cur_req, "out_im", int'(out_im), e.im);
                end
            end
        end
    end

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        do_reset();
        // R2: constant input, metric is |x|^2 on the real axis
        cur_req = "R2";
        for (int k = 0; k < 60; k++) push(500, -300);
        idle(30);
        // R3: amplitude step seen through the smoother
        cur_req = "R3";
        for (int k = 0; k < 20; k++) push(200, 100);
        for (int k = 0; k < 40; k++) push(1800, 900);
        idle(30);
        // R5: slow tone, accumulator tracks and removes rotation
        cur_req = "R5";
        tone(0.02, 1500.0, 120, 0);
        idle(30);
        // R8: same kind of tone with idle gaps inside the stream
        cur_req = "R8";
        tone(-0.04, 1200.0, 120, 3);
        idle(30);
        // R4: metric in the left half-plane forces pre-rotation
        cur_req = "R4";
        tone(0.45, 1400.0, 80, 0);
        idle(30);
        // R6: faster tone walks the whole table
        cur_req = "R6";
        tone(0.13, 1700.0, 150, 0);
        idle(30);
        // R7: full-scale corners drive the rounding into saturation
        cur_req = "R7";
        for (int k = 0; k < 40; k++) begin
            if (k % 2 == 0) push(-2048, -2048);
            else            push(2047, -2048);
        end
        idle(30);
        // R9: reset while samples are in flight, then restart from clean state
        cur_req = "R9";
        tone(0.07, 1000.0, 15, 0);
        do_reset();
        tone(-0.1, 1300.0, 60, 0);
        idle(30);
        finish_up();
    end

endmodule